// File: doc/BRIEF.md
# Sampling-Point Tuning Window Search

This engine picks the receive sampling tap for a high-speed eMMC link. It starts when `start_i` is pulsed while the bus speed mode is HS200. It then walks a 6-bit tap upward from zero over the usable taps. For each tap it does two things in order. First it applies the tap through a request/acknowledge handshake that clears itself. Then it asks an external agent to run one tuning-block transfer and reads back a pass or fail verdict. The engine does not generate the tuning command and does not compare the tuning data.

Two counts are kept during the sweep: the current run of consecutive passing taps and the longest such run seen so far. After the last tap, the engine moves the tap to the middle of the longest passing window and applies it with the same handshake. It then signals completion. If no tap passes, it raises an error instead. A start request made in any other speed mode goes to a generic tuning path through a one-cycle hand-off pulse, and the engine itself stays idle.

Top module: `tap_window_tuner`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `err_o`, `generic_o`, `tap_req_o` and `test_req_o` are all 0.
- R2: A start pulse while `mode_i` is not 4 (the HS200 code of the 3-bit mode field; 0 is SD, 2 MMC SDR, 3 MMC DDR, 5 HS400) produces a one-cycle `generic_o` pulse in the next cycle. `busy_o` stays 0 and no tap update or test is requested.
- R3: In HS200 mode the taps are tested in strictly ascending order from 0. The tap never goes above 39, and each tap whose update succeeds is tested exactly once.
- R4: `tap_o` is held stable while `tap_req_o` is high. `tap_req_o` drops in the cycle after `tap_ack_i` is seen. A test is requested only after the tap update has been acknowledged, and never while `tap_req_o` is high.
- R5: If `tap_ack_i` does not arrive within 16 cycles of request, `tap_req_o` is withdrawn. That tap then counts as a failure (it ends the current run) and it is not tested.
- R6: The final tap equals the last tap of the longest run of consecutive passing taps, minus half that run's length rounded down.
- R7: When two runs have the same length, the earlier run is kept.
- R8: If no tap passes, `err_o` pulses for one cycle, no final tap update is requested, and `done_o` stays 0.
- R9: After a successful final tap update, `done_o` pulses for one cycle and `tap_o` holds the final tap. `done_o` and `err_o` are never high together.
- R10: `busy_o` rises the cycle after an accepted start and falls together with the `done_o` or `err_o` pulse. Start pulses while busy are ignored.
- R11: If the final tap update times out, `err_o` pulses and `done_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request pulse |
| mode_i | input | 3 | Current bus speed mode code |
| tap_o | output | 6 | Sampling tap presented to the receive path |
| tap_req_o | output | 1 | Tap update request, held until acknowledged or timed out |
| tap_ack_i | input | 1 | Tap has taken effect |
| test_req_o | output | 1 | Request for one tuning-block transfer at the current tap |
| test_vld_i | input | 1 | Verdict for the requested transfer is valid |
| test_pass_i | input | 1 | Verdict: 1 pass, 0 fail |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle pulse: final tap applied |
| err_o | output | 1 | One-cycle pulse: no passing tap or final update failed |
| generic_o | output | 1 | One-cycle hand-off pulse to the generic tuning path |

## Verification
The hardest states to reach from the ports are the ones where a tap update never completes. This happens both in the middle of a sweep, where a silent tap must split a passing window, and at the final update, where the engine must report an error after a window was already found. The bench's device model counts update requests and withholds the acknowledge for one chosen request index. It can therefore make a single mid-sweep tap time out inside a passing window, or make only the final update time out. Tie-breaking between runs of equal length is reached with pass masks that contain two windows of the same size.

// File: rtl/tuner_pkg.sv
package tuner_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_KICK,
    ST_UPD,
    ST_TEST,
    ST_DECIDE,
    ST_FKICK,
    ST_FUPD
  } tuner_state_e;
endpackage

// File: rtl/tap_update_ctl.sv
module tap_update_ctl #(
  parameter int TIMEOUT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick_i,
  input  logic ack_i,
  output logic req_o,
  output logic ok_o,
  output logic fail_o
);
  localparam int CW = $clog2(TIMEOUT + 1);

  logic          req_q, req_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          expire;

  assign expire = (cnt_q == CW'(TIMEOUT - 1));
  assign ok_o   = req_q & ack_i;
  assign fail_o = req_q & ~ack_i & expire;
  assign req_o  = req_q;

  always_comb begin
    req_d = req_q;
    cnt_d = cnt_q;
    if (kick_i) begin
      req_d = 1'b1;
      cnt_d = '0;
    end else if (req_q) begin
      if (ack_i || expire) req_d = 1'b0;
      else                 cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      req_q <= req_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/streak_tracker.sv
module streak_tracker #(
  parameter int TAP_W = 6,
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             hit_i,
  input  logic             miss_i,
  input  logic [TAP_W-1:0] tap_i,
  output logic [LEN_W-1:0] best_len_o,
  output logic [TAP_W-1:0] best_end_o
);
  logic [LEN_W-1:0] cur_q, cur_d, best_q, best_d, cur_inc;
  logic [TAP_W-1:0] end_q, end_d;

  assign cur_inc = cur_q + 1'b1;

  always_comb begin
    cur_d  = cur_q;
    best_d = best_q;
    end_d  = end_q;
    if (clr_i) begin
      cur_d  = '0;
      best_d = '0;
      end_d  = '0;
    end else if (hit_i) begin
      cur_d = cur_inc;
      if (cur_inc > best_q) begin
        best_d = cur_inc;
        end_d  = tap_i;
      end
    end else if (miss_i) begin
      cur_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      best_q <= '0;
      end_q  <= '0;
    end else begin
      cur_q  <= cur_d;
      best_q <= best_d;
      end_q  <= end_d;
    end
  end

  assign best_len_o = best_q;
  assign best_end_o = end_q;
endmodule

// File: rtl/tap_window_tuner.sv
module tap_window_tuner
  import tuner_pkg::*;
#(
  parameter int TAP_W       = 6,
  parameter int NUM_TAPS    = 40,
  parameter int UPD_TIMEOUT = 16,
  parameter int MODE_W      = 3,
  parameter int HS200_MODE  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic [TAP_W-1:0]  tap_o,
  output logic              tap_req_o,
  input  logic              tap_ack_i,
  output logic              test_req_o,
  input  logic              test_vld_i,
  input  logic              test_pass_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              generic_o
);
  localparam int LEN_W = $clog2(NUM_TAPS + 1);
  localparam logic [TAP_W-1:0] LAST_TAP = TAP_W'(NUM_TAPS - 1);

  tuner_state_e     state_q, state_d;
  logic [TAP_W-1:0] tap_q, tap_d;
  logic             done_d, err_d, gen_d;
  logic             done_q, err_q, gen_q;
  logic             kick, upd_ok, upd_fail;
  logic             clr, hit, miss;
  logic [LEN_W-1:0] best_len;
  logic [TAP_W-1:0] best_end;
  logic [TAP_W-1:0] centre;

  assign centre = best_end - TAP_W'(best_len >> 1);
  assign kick   = (state_q == ST_KICK) || (state_q == ST_FKICK);

  tap_update_ctl #(.TIMEOUT(UPD_TIMEOUT)) u_upd (
    .clk    (clk),
    .rst_n  (rst_n),
    .kick_i (kick),
    .ack_i  (tap_ack_i),
    .req_o  (tap_req_o),
    .ok_o   (upd_ok),
    .fail_o (upd_fail)
  );

  streak_tracker #(.TAP_W(TAP_W), .LEN_W(LEN_W)) u_streak (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clr),
    .hit_i      (hit),
    .miss_i     (miss),
    .tap_i      (tap_q),
    .best_len_o (best_len),
    .best_end_o (best_end)
  );

  always_comb begin
    state_d = state_q;
    tap_d   = tap_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    gen_d   = 1'b0;
    clr     = 1'b0;
    hit     = 1'b0;
    miss    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (mode_i == MODE_W'(HS200_MODE)) begin
            state_d = ST_KICK;
            tap_d   = '0;
            clr     = 1'b1;
          end else begin
            gen_d = 1'b1;
          end
        end
      end
      ST_KICK: state_d = ST_UPD;
      ST_UPD: begin
        if (upd_ok) begin
          state_d = ST_TEST;
        end else if (upd_fail) begin
          miss = 1'b1;
          if (tap_q == LAST_TAP) state_d = ST_DECIDE;
          else begin
            tap_d   = tap_q + 1'b1;
            state_d = ST_KICK;
          end
        end
      end
      ST_TEST: begin
        if (test_vld_i) begin
          hit  = test_pass_i;
          miss = ~test_pass_i;
          if (tap_q == LAST_TAP) state_d = ST_DECIDE;
          else begin
            tap_d   = tap_q + 1'b1;
            state_d = ST_KICK;
          end
        end
      end
      ST_DECIDE: begin
        if (best_len == '0) begin
          err_d   = 1'b1;
          state_d = ST_IDLE;
        end else begin
          tap_d   = centre;
          state_d = ST_FKICK;
        end
      end
      ST_FKICK: state_d = ST_FUPD;
      ST_FUPD: begin
        if (upd_ok) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else if (upd_fail) begin
          err_d   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tap_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      gen_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      tap_q   <= tap_d;
      done_q  <= done_d;
      err_q   <= err_d;
      gen_q   <= gen_d;
    end
  end

  assign tap_o      = tap_q;
  assign test_req_o = (state_q == ST_TEST);
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign generic_o  = gen_q;
endmodule

// File: rtl/tuner_checker.sv
module tuner_checker #(
  parameter int TAP_W       = 6,
  parameter int NUM_TAPS    = 40,
  parameter int UPD_TIMEOUT = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [TAP_W-1:0] tap_o,
  input logic             tap_req_o,
  input logic             test_req_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             err_o,
  input logic             generic_o
);
  localparam int CW = $clog2(UPD_TIMEOUT + 2);
  logic [CW-1:0] req_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   req_len <= '0;
    else if (!tap_req_o)                          req_len <= '0;
    else if (req_len != CW'(UPD_TIMEOUT + 1))     req_len <= req_len + 1'b1;
  end

  AST_TAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    tap_req_o && $past(tap_req_o) |-> $stable(tap_o)); // R4
  AST_NO_TEST_IN_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    !(tap_req_o && test_req_o)); // R4
  AST_TAP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    test_req_o |-> (tap_o < TAP_W'(NUM_TAPS))); // R3
  AST_REQ_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    req_len <= CW'(UPD_TIMEOUT)); // R5
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !test_req_o && !tap_req_o); // R10
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || err_o) |-> !busy_o); // R10
  AST_GENERIC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    generic_o |-> !busy_o && !$past(busy_o)); // R2
endmodule

bind tap_window_tuner tuner_checker #(
  .TAP_W(TAP_W), .NUM_TAPS(NUM_TAPS), .UPD_TIMEOUT(UPD_TIMEOUT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tap_o      (tap_o),
  .tap_req_o  (tap_req_o),
  .test_req_o (test_req_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .generic_o  (generic_o)
);

// File: tb/tb_tap_window_tuner.sv
module tb_tap_window_tuner;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [2:0] mode_i = 3'd4;
  logic [5:0] tap_o;
  logic       tap_req_o, test_req_o, busy_o, done_o, err_o, generic_o;
  logic       tap_ack_i = 1'b0;
  logic       test_vld_i = 1'b0;
  logic       test_pass_i = 1'b0;

  int n_chk = 0, n_fail = 0, cyc = 0;

  logic [39:0] mask;
  int blk_idx = -1;
  int upd_cnt = 0, cur_idx = 0, ack_cnt = 0;
  int tested = 0, last_tap = -1, order_err = 0, hs_err = 0;
  logic prev_req = 1'b0;

  always #5 clk = ~clk;

  tap_window_tuner dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .tap_o(tap_o), .tap_req_o(tap_req_o), .tap_ack_i(tap_ack_i),
    .test_req_o(test_req_o), .test_vld_i(test_vld_i), .test_pass_i(test_pass_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .generic_o(generic_o)
  );

  // device model: acknowledges tap updates, answers tuning transfers
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (tap_req_o && !prev_req) begin
      cur_idx = upd_cnt;
      upd_cnt = upd_cnt + 1;
    end
    prev_req = tap_req_o;
    if (!tap_req_o) begin
      ack_cnt = 0;
      tap_ack_i = 1'b0;
    end else if (cur_idx != blk_idx) begin
      ack_cnt = ack_cnt + 1;
      tap_ack_i = (ack_cnt >= 2);
    end
    if (test_req_o && !test_vld_i) begin
      if (tap_req_o) hs_err = hs_err + 1;
      if (int'(tap_o) <= last_tap || tap_o > 6'd39) order_err = order_err + 1;
      last_tap = int'(tap_o);
      test_vld_i = 1'b1;
      test_pass_i = (tap_o <= 6'd39) ? mask[tap_o] : 1'b0;
      tested = tested + 1;
    end else begin
      test_vld_i = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // lo1,hi1,lo2,hi2 (empty when hi<lo), blocked update index, expected tap, expected error
  localparam int NV = 8;
  localparam int VEC [NV][7] = '{
    '{10, 19,  1,  0, -1, 14, 0},   // R6 single window
    '{ 5,  7, 20, 29, -1, 24, 0},   // R6 longer later window wins
    '{ 2,  5, 30, 33, -1,  3, 0},   // R7 tie keeps earlier
    '{ 0, 39,  1,  0, -1, 19, 0},   // R6 all pass
    '{ 0,  0,  1,  0, -1,  0, 0},   // R6 only tap 0
    '{39, 39,  1,  0, -1, 39, 0},   // R3 last tap reached
    '{ 1,  0,  1,  0, -1,  0, 1},   // R8 nothing passes
    '{11, 13,  1,  0, -1, 12, 0}    // R6 odd length
  };

  task automatic run(input int lo1, input int hi1, input int lo2, input int hi2,
                     input int blk, input int exp_tap, input int exp_err,
                     input bit restart, input string tag);
    bit saw_done = 0, saw_err = 0, done_seen = 0;
    int exp_tests;
    mask = '0;
    for (int i = lo1; i <= hi1; i++) mask[i] = 1'b1;
    for (int i = lo2; i <= hi2; i++) mask[i] = 1'b1;
    blk_idx = blk; upd_cnt = 0; tested = 0; last_tap = -1; order_err = 0; hs_err = 0;
    exp_tests = (blk >= 0 && blk < 40) ? 39 : 40;
    mode_i = 3'd4;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, {"R10 busy after start ", tag}, busy_o, 1);
    for (int i = 0; i < 5000 && !done_seen; i++) begin
      if (restart && i == 30) start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      if (done_o) saw_done = 1;
      if (err_o) saw_err = 1;
      if (done_o || err_o) done_seen = 1;
    end
    if (!done_seen) begin
      chk(0, {"R10 run never finished ", tag}, 0, 1);
      finish_run();
    end
    chk(busy_o == 1'b0, {"R10 busy falls with end ", tag}, busy_o, 0);
    chk(saw_err == exp_err[0], {"R8/R11 error flag ", tag}, saw_err, exp_err);
    chk(saw_done == !exp_err[0], {"R9 done flag ", tag}, saw_done, !exp_err[0]);
    if (!exp_err[0])
      chk(tap_o == 6'(exp_tap), {"R6 final tap ", tag}, tap_o, exp_tap);
    chk(tested == exp_tests, {"R3 taps tested ", tag}, tested, exp_tests);
    chk(order_err == 0, {"R3 ascending order ", tag}, order_err, 0);
    chk(hs_err == 0, {"R4 test during update ", tag}, hs_err, 0);
    if (exp_err[0] && blk != 40)
      chk(upd_cnt == 40, {"R8 no final update ", tag}, upd_cnt, 40);
    else
      chk(upd_cnt == 41, {"R9 final update issued ", tag}, upd_cnt, 41);
    @(negedge clk);
    chk(!done_o && !err_o, {"R9 pulse one cycle ", tag}, done_o | err_o, 0);
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        finish_run();
      end
    join_none
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({busy_o, done_o, err_o, generic_o, tap_req_o, test_req_o} == 6'b0,
        "R1 reset outputs", {busy_o, done_o, err_o, generic_o, tap_req_o, test_req_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy_o == 1'b0, "R1 idle after reset", busy_o, 0);

    for (int v = 0; v < NV; v++)
      run(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5], VEC[v][6],
          1'b0, $sformatf("vec%0d", v));

    // R5 mid-sweep update timeout splits window 10..19 into 10..14 and 16..19
    run(10, 19, 1, 0, 15, 12, 0, 1'b0, "r5_timeout");
    // R11 final update times out
    run(10, 19, 1, 0, 40, 0, 1, 1'b0, "r11_final_timeout");
    // R10 start while busy is ignored
    run(5, 7, 20, 29, -1, 24, 0, 1'b1, "r10_restart");

    // R2 other modes go to the generic path
    foreach (VEC[k]) begin end
    for (int m = 0; m < 8; m++) begin
      if (m == 4) continue;
      upd_cnt = 0; tested = 0;
      mode_i = 3'(m);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(generic_o == 1'b1 && busy_o == 1'b0, $sformatf("R2 hand-off mode %0d", m),
          {generic_o, busy_o}, 2);
      repeat (5) @(negedge clk);
      chk(generic_o == 1'b0 && upd_cnt == 0 && tested == 0,
          $sformatf("R2 engine quiet mode %0d", m), upd_cnt + tested + generic_o, 0);
    end

    // R1 reset mid-run
    mode_i = 3'd4;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk({busy_o, tap_req_o, test_req_o} == 3'b0, "R1 reset during run",
        {busy_o, tap_req_o, test_req_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule